// File: doc/BRIEF.md
# Sector-interleaved four-channel data router

This block sits between one wide user-side FIFO pair and four per-channel FIFO pairs of a striped storage array. For a write command it drains 128-bit beats from the user transmit FIFO and fills the channel transmit FIFOs. For a read command it drains the channel receive FIFOs and fills the user receive FIFO. Data always moves one 512-byte sector at a time, which is 32 beats. Each sector goes to or comes from exactly one channel, and the channel steps forward after every sector.

A controller starts the router with a single-cycle pulse. The pulse carries the direction, the channel that takes the first sector and the number of sectors. Before each sector the router compares the FIFO occupancy counts on both sides against fixed thresholds. Once a sector has begun, it runs to the end without further checks. The router pulses a completion flag after the last sector has landed.

Top module: `sector_router`

## Requirements
- R1: After reset the router is idle. `busy` and `done` are low, and no FIFO read or write enable is high.
- R2: Each sector is moved as exactly 32 consecutive cycles of the source read enable. At most one source read enable is high in any cycle, and at least one idle cycle separates two sectors.
- R3: A write sector starts only when two conditions hold. Bits 15:5 of `utx_cnt` must be nonzero, which means at least 32 beats are available. Bits 15:6 of the active channel's `ctx_cnt` must not all be ones, which means room for 64 beats. The counts of the other channels have no effect.
- R4: A read sector starts only when two conditions hold. Bits 15:5 of the active channel's `crx_cnt` must be nonzero. Bits 15:6 of `urx_cnt` must not all be ones.
- R5: Sector k of a command (k starting at 0) uses channel (`first_ch` + k) mod 4. The channel index wraps from 3 to 0.
- R6: Each destination write happens one cycle after its source read. The data passes through unchanged and in order. Only the channel that was read (`urx_wr`) or the channel being filled (bit `ch` of `ctx_wr`) is written.
- R7: After `nsect` sectors (`nsect` × 32 beats), `done` pulses for one cycle, in the same cycle as the final destination write. `busy` is low in the following cycle.
- R8: A start with `nsect` = 0 moves no data. It pulses `done` one cycle later, and `busy` stays low.
- R9: A `start` pulse while `busy` is high is ignored. `utx_empty` has no effect.
- R10: Occupancy counts are sampled only before a sector begins. A count that falls below its threshold mid-sector does not shorten that sector, but it does hold the next sector back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command start pulse |
| dir | input | 1 | 0 = write (user to channels), 1 = read (channels to user) |
| first_ch | input | 2 | Channel of the first sector |
| nsect | input | 16 | Number of sectors to move |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| utx_cnt | input | 16 | User transmit FIFO occupancy in beats |
| utx_empty | input | 1 | User transmit FIFO empty flag (ignored) |
| utx_rd | output | 1 | User transmit FIFO read enable |
| utx_data | input | 128 | User transmit FIFO data, valid one cycle after read |
| urx_cnt | input | 16 | User receive FIFO count, upper bits padded with ones |
| urx_wr | output | 1 | User receive FIFO write enable |
| urx_data | output | 128 | User receive FIFO write data |
| ctx_cnt | input | 4×16 | Channel transmit FIFO counts, upper bits padded with ones |
| ctx_wr | output | 4 | Channel transmit FIFO write enables |
| ctx_data | output | 128 | Shared channel transmit write data |
| crx_cnt | input | 4×16 | Channel receive FIFO occupancy in beats |
| crx_rd | output | 4 | Channel receive FIFO read enables |
| crx_data | input | 4×128 | Channel receive FIFO data, valid one cycle after read |

## Verification
The bench sweeps both directions, every starting channel and sector counts from 1 to 6. It checks the channel and the data of every beat. This catches a rotation that fails to wrap or starts on the wrong channel, and a write strobe that is not delayed to line up with the returned data, which would shift every beat by one. Each threshold is tested one count below and exactly at its limit, on the active channel only. An off-by-one compare would start a sector too early or hang forever. A count that drops mid-sector must not stall the burst; a design that re-checks counts every cycle would split the sector. A second start while busy, the ignored empty flag and a zero-sector command check that the router neither restarts nor hangs.

// File: rtl/sector_router.sv
module sector_router #(
  parameter int NCH   = 4,
  parameter int DW    = 128,
  parameter int BEATS = 32,
  parameter int CW    = 16,
  parameter int SW    = 16,
  localparam int CHW  = $clog2(NCH),
  localparam int SB   = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    dir,
  input  logic [CHW-1:0]          first_ch,
  input  logic [SW-1:0]           nsect,
  output logic                    busy,
  output logic                    done,
  input  logic [CW-1:0]           utx_cnt,
  input  logic                    utx_empty,
  output logic                    utx_rd,
  input  logic [DW-1:0]           utx_data,
  input  logic [CW-1:0]           urx_cnt,
  output logic                    urx_wr,
  output logic [DW-1:0]           urx_data,
  input  logic [NCH-1:0][CW-1:0]  ctx_cnt,
  output logic [NCH-1:0]          ctx_wr,
  output logic [DW-1:0]           ctx_data,
  input  logic [NCH-1:0][CW-1:0]  crx_cnt,
  output logic [NCH-1:0]          crx_rd,
  input  logic [NCH-1:0][DW-1:0]  crx_data
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BURST} st_t;

  st_t            st;
  logic           rd_dir, dir_q, wr_q, done_r;
  logic [CHW-1:0] ch, ch_q, ch_nxt;
  logic [SB-1:0]  beat;
  logic [SW-1:0]  left;

  logic unused_inputs;
  assign unused_inputs = ^{utx_empty, utx_cnt, urx_cnt, ctx_cnt, crx_cnt};

  wire src_ok_w = utx_cnt[CW-1:SB] != '0;
  wire dst_ok_w = !(&ctx_cnt[ch][CW-1:SB+1]);
  wire src_ok_r = crx_cnt[ch][CW-1:SB] != '0;
  wire dst_ok_r = !(&urx_cnt[CW-1:SB+1]);
  wire gate_ok  = rd_dir ? (src_ok_r && dst_ok_r) : (src_ok_w && dst_ok_w);
  wire go       = st == S_BURST;
  wire last     = beat == SB'(BEATS - 1);

  assign ch_nxt = (ch == CHW'(NCH - 1)) ? '0 : ch + 1'b1;

  assign utx_rd   = go && !rd_dir;
  assign urx_wr   = wr_q && dir_q;
  assign urx_data = crx_data[ch_q];
  assign ctx_data = utx_data;
  assign busy     = (st != S_IDLE) || wr_q;
  assign done     = done_r;

  always_comb begin
    crx_rd = '0;
    ctx_wr = '0;
    if (go && rd_dir)  crx_rd[ch]   = 1'b1;
    if (wr_q && !dir_q) ctx_wr[ch_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rd_dir <= 1'b0;
      dir_q  <= 1'b0;
      wr_q   <= 1'b0;
      done_r <= 1'b0;
      ch     <= '0;
      ch_q   <= '0;
      beat   <= '0;
      left   <= '0;
    end else begin
      wr_q   <= go;
      ch_q   <= ch;
      dir_q  <= rd_dir;
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd_dir <= dir;
          ch     <= first_ch;
          left   <= nsect;
          beat   <= '0;
          if (nsect == '0) done_r <= 1'b1;
          else             st     <= S_WAIT;
        end
        S_WAIT: if (gate_ok) begin
          st   <= S_BURST;
          beat <= '0;
        end
        S_BURST: begin
          beat <= beat + 1'b1;
          if (last) begin
            ch   <= ch_nxt;
            left <= left - 1'b1;
            if (left == SW'(1)) begin
              st     <= S_IDLE;
              done_r <= 1'b1;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sector_router_chk.sv
module sector_router_chk #(
  parameter int NCH   = 4,
  parameter int DW    = 128,
  parameter int BEATS = 32,
  parameter int CW    = 16,
  parameter int SW    = 16,
  localparam int CHW  = $clog2(NCH),
  localparam int SB   = $clog2(BEATS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    dir,
  input logic [CHW-1:0]          first_ch,
  input logic [SW-1:0]           nsect,
  input logic                    busy,
  input logic                    done,
  input logic [CW-1:0]           utx_cnt,
  input logic                    utx_empty,
  input logic                    utx_rd,
  input logic [DW-1:0]           utx_data,
  input logic [CW-1:0]           urx_cnt,
  input logic                    urx_wr,
  input logic [DW-1:0]           urx_data,
  input logic [NCH-1:0][CW-1:0]  ctx_cnt,
  input logic [NCH-1:0]          ctx_wr,
  input logic [DW-1:0]           ctx_data,
  input logic [NCH-1:0][CW-1:0]  crx_cnt,
  input logic [NCH-1:0]          crx_rd,
  input logic [NCH-1:0][DW-1:0]  crx_data
);

  wire any_rd = utx_rd || (|crx_rd);
  logic [SB+1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (any_rd) run <= run + 1'b1;
    else             run <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!any_rd && !urx_wr && ctx_wr == '0)); // R1
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({utx_rd, crx_rd})); // R2
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_rd) |-> run == (SB+2)'(BEATS)); // R2
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    run <= (SB+2)'(BEATS)); // R2
  AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(utx_rd) |-> $past(utx_cnt[CW-1:SB] != '0)); // R3
  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|crx_rd) |-> $past(!(&urx_cnt[CW-1:SB+1]))); // R4
  AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({urx_wr, ctx_wr})); // R6
  AST_CTX_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctx_wr) |-> $past(utx_rd)); // R6
  AST_URX_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    urx_wr |-> $past(|crx_rd)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7

endmodule

bind sector_router sector_router_chk #(
  .NCH(NCH), .DW(DW), .BEATS(BEATS), .CW(CW), .SW(SW)
) u_chk (.*);

// File: tb/test_sector_router.sv
module test_sector_router;
  localparam int NCH = 4;
  localparam int DW  = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, clr = 1'b0;
  logic [1:0] first_ch = '0;
  logic [15:0] nsect = '0;
  logic busy, done, utx_rd, urx_wr;
  logic utx_empty = 1'b1;
  logic [15:0] utx_cnt = 16'h0100, urx_cnt = 16'h0000;
  logic [DW-1:0] utx_data = '0, urx_data, ctx_data;
  logic [NCH-1:0][15:0] ctx_cnt, crx_cnt;
  logic [NCH-1:0] ctx_wr, crx_rd;
  logic [NCH-1:0][DW-1:0] crx_data;

  int total = 0, bad = 0;
  int tk = 0, rk = 0;
  int beat_cnt = 0, done_cnt = 0, exp_n = 0, exp_first = 0;
  logic exp_dir = 1'b0;

  always #10 clk = ~clk;

  sector_router i_sector_router (.*);

  function automatic logic [DW-1:0] pat(int c, int k);
    return {32'hA5000000 + 32'(c), 32'(k), ~32'(k), 32'(k * 7 + c)};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (clr) begin
      tk <= 0;
      rk <= 0;
    end else begin
      if (utx_rd) begin
        utx_data <= pat(0, tk);
        tk <= tk + 1;
      end
      for (int i = 0; i < NCH; i++)
        if (crx_rd[i]) crx_data[i] <= pat(i, rk);
      if (|crx_rd) rk <= rk + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ech;
      ech = (exp_first + beat_cnt / 32) % NCH;
      if (|ctx_wr) begin
        check(!exp_dir, "R6", "write strobe in read cmd", 1, 0);
        check(ctx_wr == NCH'(1 << ech), "R5", "ctx_wr channel", longint'(ctx_wr), longint'(1 << ech));
        check(ctx_data == pat(0, beat_cnt), "R6", "ctx_data", longint'(ctx_data[31:0]), longint'(pat(0, beat_cnt)));
        beat_cnt++;
      end
      if (urx_wr) begin
        check(exp_dir, "R6", "urx write in write cmd", 1, 0);
        check(urx_data == pat(ech, beat_cnt), "R5", "urx_data channel/data", longint'(urx_data[127:96]), longint'(pat(ech, beat_cnt)) >>> 0);
        beat_cnt++;
      end
      if (done) begin
        done_cnt++;
        check(beat_cnt == exp_n * 32, "R7", "beats at done", beat_cnt, exp_n * 32);
      end
    end
  end

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic start_cmd(bit d, int fc, int n);
    @(negedge clk);
    dir = d; first_ch = 2'(fc); nsect = 16'(n);
    exp_dir = d; exp_first = fc; exp_n = n;
    beat_cnt = 0; done_cnt = 0;
    start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
  endtask

  task automatic finish_cmd(string req);
    int w = 0;
    while (done_cnt == 0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    check(done_cnt == 1, req, "done seen", done_cnt, 1);
    check(beat_cnt == exp_n * 32, req, "total beats", beat_cnt, exp_n * 32);
    @(negedge clk);
    check(!busy, "R7", "busy after done", busy, 0);
  endtask

  task automatic stay_blocked(string req);
    repeat (40) @(negedge clk);
    check(busy && beat_cnt == 0, req, "sector held back", beat_cnt, 0);
  endtask

  initial begin
    ctx_cnt = '0;
    crx_cnt = {NCH{16'h0100}};
    crx_data = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !utx_rd && crx_rd == '0 && ctx_wr == '0 && !urx_wr,
          "R1", "reset state", busy, 0);
    rst_n = 1'b1;

    // R5 R6 R7 R9 sweep: both directions, all first channels, 1..6 sectors, empty flag held high
    for (int d = 0; d < 2; d++)
      for (int fc = 0; fc < NCH; fc++)
        for (int n = 1; n <= 6; n++) begin
          start_cmd(d[0], fc, n);
          finish_cmd("R5");
        end

    // R3: user source one beat short, then exactly one sector
    utx_cnt = 16'd31;
    start_cmd(1'b0, 2, 1);
    stay_blocked("R3");
    utx_cnt = 16'd32;
    finish_cmd("R3");

    // R3: active channel space at limit; a full neighbour has no effect
    utx_cnt = 16'h0100;
    ctx_cnt[2] = 16'hFFC0; ctx_cnt[3] = 16'hFFFF;
    start_cmd(1'b0, 2, 1);
    stay_blocked("R3");
    ctx_cnt[2] = 16'hFFBF;
    finish_cmd("R3");
    ctx_cnt = '0;

    // R4: channel source short, then enough
    crx_cnt[1] = 16'd31;
    start_cmd(1'b1, 1, 1);
    stay_blocked("R4");
    crx_cnt[1] = 16'd32;
    finish_cmd("R4");

    // R4: user receive space at limit
    urx_cnt = 16'hFFC0;
    start_cmd(1'b1, 3, 2);
    stay_blocked("R4");
    urx_cnt = 16'hFFBF;
    finish_cmd("R4");
    urx_cnt = 16'h0000;

    // R10: source drains mid-sector
    start_cmd(1'b0, 0, 2);
    while (!utx_rd) @(negedge clk);
    repeat (5) @(negedge clk);
    utx_cnt = 16'd0;
    repeat (60) @(negedge clk);
    check(beat_cnt == 32, "R10", "first sector completes, second waits", beat_cnt, 32);
    utx_cnt = 16'h0100;
    finish_cmd("R10");

    // R9: start while busy is ignored
    start_cmd(1'b1, 3, 2);
    repeat (10) @(negedge clk);
    dir = 1'b0; first_ch = 2'd0; nsect = 16'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_cmd("R9");

    // R8: zero sectors
    start_cmd(1'b0, 1, 0);
    check(done && !busy, "R8", "immediate done", done, 1);
    @(negedge clk);
    check(!busy && beat_cnt == 0 && done_cnt == 1, "R8", "no data, idle", beat_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule